// File: doc/BRIEF.md
# Bit-Serial Four-Bit Adder Datapath

This block adds two unsigned 4-bit operands one bit per clock instead of with a combinational ripple adder. On a load strobe each operand is copied into its own shift register. Over the following four clocks both registers present their bits lowest first to a single full adder. The adder's carry-out is kept in a one-bit carry register and fed back as the next carry-in. Each sum bit is shifted into a collector register. Once per four-clock period, a capture strobe copies the aligned collector contents into the parallel result register that drives `sum_o`.

An external sequencer supplies the three strobes on a fixed four-cycle rhythm:
- The load strobe and the carry-clear strobe are high together in one cycle.
- The capture strobe is high in the cycle right after that load.
- No strobe is high in the other two cycles.

With this rhythm, the result of a word loaded at clock edge k appears on `sum_o` just after edge k+5. The carry-out of the top bit is discarded, so the sum wraps modulo 16. If the clear strobe is withheld at a load, that carry is kept as the carry-in of the next word's lowest bit.

Top module: `serial_add_core`

## Requirements
- R1: `op_a_i` and `op_b_i` are sampled only at a rising edge where `load_i` is 1; operand values applied in any other cycle do not change any result.
- R2: After a load, the two operands are presented to the adder least significant bit first, advancing one bit per rising edge.
- R3: A rising edge with `carry_clr_i` = 1 forces the carry register to 0. Otherwise the register takes the adder's carry-out. Without a clear at a load edge, the previous word's top-bit carry is added into the next word's bit 0.
- R4: With the clear applied at every load, the captured result equals (A + B) mod 16, and the final carry-out is not visible at any port.
- R5: `sum_o` changes only at a rising edge where `capture_i` is 1 and holds its value at every other edge.
- R6: With load and clear at edge k and capture at edge k+5 (the edge after the next load), `sum_o` after edge k+5 is the result of the word loaded at edge k.
- R7: The collector takes each new sum bit into its most significant position, so after four bits the first bit computed sits in bit 0 of the captured result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| op_a_i | input | 4 | First operand, sampled on load |
| op_b_i | input | 4 | Second operand, sampled on load |
| load_i | input | 1 | Load strobe: copy both operands into their shift registers |
| carry_clr_i | input | 1 | Synchronous clear of the carry register |
| capture_i | input | 1 | Copy the collector into the result register |
| sum_o | output | 4 | Parallel sum from the last capture |

## Verification
The hardest case to reach is a carry crossing a word boundary, because the normal strobe rhythm always clears the carry. The bench therefore runs the full sweep of 256 operand pairs with the clear applied. It then sends short word chains with the clear deliberately withheld, after words whose top bit carries out, and expects the leaked carry in the following result. Between loads, the bench drives unrelated operand values, so any sampling outside the load edge would corrupt a result.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam int unsigned NUM_OPERANDS = 2;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    function automatic fa_res_t full_add(input logic a, input logic b, input logic cin);
        fa_res_t r;
        r.sum   = a ^ b ^ cin;
        r.carry = (a & b) | (cin & (a ^ b));
        return r;
    endfunction

endpackage

// File: rtl/sa_operand_shifter.sv
module sa_operand_shifter #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bits = par_i;
        end else begin
            st_d.bits = {1'b0, st_q.bits[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign ser_o = st_q.bits[0];

    logic chk_armed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        chk_armed_q <= 1'b1;
    end

    // R1: a load presents the operand's lowest bit on the next cycle
    a_r1_load_lsb: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        load_i |=> ser_o == $past(par_i[0]));

    // R2: without a load the next higher bit moves to the serial output
    a_r2_shift_order: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        !load_i |=> ser_o == $past(st_q.bits[1]));

endmodule

// File: rtl/sa_bit_adder.sv
module sa_bit_adder
    import sa_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);

    fa_res_t res;

    always_comb begin
        res    = full_add(a_i, b_i, cin_i);
        sum_o  = res.sum;
        cout_o = res.carry;
    end

endmodule

// File: rtl/sa_carry_reg.sv
module sa_carry_reg (
    input  logic clk_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);

    typedef struct packed {
        logic carry;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.carry = 1'b0;
        end else begin
            st_d.carry = d_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.carry;

    logic chk_armed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        chk_armed_q <= 1'b1;
    end

    // R3: a clear edge leaves the carry at zero
    a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        clr_i |=> !q_o);

    // R3: without a clear the carry-out is carried into the next cycle
    a_r3_carry_follows: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        !clr_i |=> q_o == $past(d_i));

endmodule

// File: rtl/sa_result_collector.sv
module sa_result_collector #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             ser_i,
    input  logic             capture_i,
    output logic [WIDTH-1:0] par_o
);

    typedef struct packed {
        logic [WIDTH-1:0] shreg;
        logic [WIDTH-1:0] result;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.shreg = {ser_i, st_q.shreg[WIDTH-1:1]};
        if (capture_i) begin
            st_d.result = st_q.shreg;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign par_o = st_q.result;

    logic chk_armed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        chk_armed_q <= 1'b1;
    end

    // R5: the parallel result holds unless captured
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        !capture_i |=> $stable(par_o));

    // R7: a new serial bit lands in the top position
    a_r7_msb_entry: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        1'b1 |=> st_q.shreg[WIDTH-1] == $past(ser_i));

    // R6: a capture copies the collector's contents to the output
    a_r6_capture: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        capture_i |=> par_o == $past(st_q.shreg));

endmodule

// File: rtl/serial_add_core.sv
module serial_add_core
    import sa_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic             load_i,
    input  logic             carry_clr_i,
    input  logic             capture_i,
    output logic [WIDTH-1:0] sum_o
);

    logic [NUM_OPERANDS-1:0][WIDTH-1:0] ops;
    logic [NUM_OPERANDS-1:0]            ser_bits;
    logic                               sum_bit;
    logic                               carry_out;
    logic                               carry_q;

    assign ops[0] = op_a_i;
    assign ops[1] = op_b_i;

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
        sa_operand_shifter #(.WIDTH(WIDTH)) u_shift (
            .clk_i  (clk_i),
            .load_i (load_i),
            .par_i  (ops[g]),
            .ser_o  (ser_bits[g])
        );
    end

    sa_bit_adder u_adder (
        .a_i    (ser_bits[0]),
        .b_i    (ser_bits[1]),
        .cin_i  (carry_q),
        .sum_o  (sum_bit),
        .cout_o (carry_out)
    );

    sa_carry_reg u_carry (
        .clk_i (clk_i),
        .clr_i (carry_clr_i),
        .d_i   (carry_out),
        .q_o   (carry_q)
    );

    sa_result_collector #(.WIDTH(WIDTH)) u_collect (
        .clk_i     (clk_i),
        .ser_i     (sum_bit),
        .capture_i (capture_i),
        .par_o     (sum_o)
    );

    logic chk_armed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        chk_armed_q <= 1'b1;
    end

    // R3: after a load with clear, bit 0 is summed with a zero carry-in
    a_r3_clean_start: assert property (@(posedge clk_i) disable iff (!chk_armed_q)
        (load_i && carry_clr_i) |=> sum_bit == ($past(op_a_i[0]) ^ $past(op_b_i[0])));

endmodule

// File: tb/serial_add_core_test.sv
`timescale 1ns/1ps
module serial_add_core_test;

    logic       clk = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic       load = 1'b0;
    logic       clr = 1'b0;
    logic       capture = 1'b0;
    logic [3:0] sum;

    always #2.5 clk = ~clk;

    serial_add_core #(.WIDTH(4)) uut (
        .clk_i       (clk),
        .op_a_i      (op_a),
        .op_b_i      (op_b),
        .load_i      (load),
        .carry_clr_i (clr),
        .capture_i   (capture),
        .sum_o       (sum)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    carry_model = 1'b0;
    bit    first_done  = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one four-cycle period: load (+clear), capture of the previous word, two idle cycles
    task automatic add_word(input logic [3:0] a, input logic [3:0] b,
                            input bit clr_en, input string tag);
        int total;
        total       = int'(a) + int'(b) + ((clr_en || !carry_model) ? 0 : 1);
        carry_model = (total > 15);
        exp_q.push_back(total % 16);
        tag_q.push_back(tag);
        @(negedge clk);
        op_a = a; op_b = b; load = 1'b1; clr = clr_en; capture = 1'b0;
        @(negedge clk);
        load = 1'b0; clr = 1'b0; capture = first_done;
        op_a = ~a; op_b = b ^ 4'h5;          // R1: junk outside the load edge
        @(negedge clk);
        capture = 1'b0; op_a = a ^ 4'h9; op_b = ~b;
        @(negedge clk);
        op_a = 4'hf; op_b = 4'hf;
        first_done = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        load = 1'b0; clr = 1'b0; capture = 1'b0;
        @(negedge clk);
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare on capture edges, check hold (R5) on all others
    initial begin
        bit       cap;
        bit       have = 1'b0;
        int       last = 0;
        int       e;
        string    t;
        forever begin
            @(posedge clk);
            cap = capture;
            @(negedge clk);
            if (cap) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected capture", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, int'(sum), e);
                end
                last = int'(sum);
                have = 1'b1;
            end else if (have) begin
                check("R5 hold", int'(sum), last);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // first word after power-up: carry cleared, plain sum (R3 start state)
        add_word(4'd9, 4'd9, 1'b1, "R3 first word cleared");
        // full sweep with the clear at every load
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                add_word(4'(a), 4'(b), 1'b1, "R1 R2 R4 R6 R7 sweep");
            end
        end
        // carry leak when the clear is withheld
        add_word(4'd15, 4'd15, 1'b1, "R4 wrap 30");
        add_word(4'd0,  4'd0,  1'b0, "R3 leaked carry into 0+0");
        add_word(4'd8,  4'd8,  1'b1, "R4 wrap 16");
        add_word(4'd7,  4'd8,  1'b0, "R3 leaked carry 7+8+1");
        add_word(4'd0,  4'd0,  1'b0, "R3 chained carry");
        add_word(4'd1,  4'd1,  1'b1, "R4 small");
        add_word(4'd2,  4'd3,  1'b0, "R3 no carry to leak");
        add_word(4'd1,  4'd0,  1'b1, "R7 single low bit");
        add_word(4'd0,  4'd8,  1'b1, "R7 single high bit");
        flush();
        check("R6 all results drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule